// File: doc/BRIEF.md
# Capability Store Dirty Tracker

This block decides what happens to a capability store, a capability store-conditional or a capability AMO once address translation has found the leaf page-table entry. It looks at the entry's capability write-enable, capability-dirty and generation bits and at the tag of the capability about to be written. From these it picks one of three outcomes: the access proceeds, a store-capability fault is raised, or the entry is updated to mark the page as holding capabilities. The mode input chooses the trapping scheme, where software keeps the dirty bit, or the updating scheme, where hardware keeps it.

In the updating scheme the block runs a read-compare-write sequence on the entry through a simple read and write handshake. The write is a compare-and-swap that the memory side may refuse. On refusal the block re-reads the entry and tries again, up to a bounded number of attempts. For an AMO the block also resolves the priority between its own store fault and a load-capability fault candidate that the load checker supplies.

The controller has four states. IDLE accepts a request. READ waits for the re-read entry. WRITE waits for the compare-and-swap result. RESP presents the result for one cycle. The transitions are: IDLE→READ when a request needs a hardware update; IDLE→RESP for every other request; READ→RESP when the re-read entry has lost write-enable or already has capability-dirty set; READ→WRITE otherwise; WRITE→RESP on a successful swap or on the last refused attempt; WRITE→READ on a refused swap with attempts left; RESP→IDLE always.

Top module: `cap_dirty_tracker`

## Requirements
- R1: For an entry with write-enable 0, capability-dirty 0 and generation 0, a set store tag gives a store fault, and a clear store tag lets the access proceed.
- R2: An entry with write-enable 0 and capability-dirty 1 is reserved. So is an entry with write-enable 0, capability-dirty 0 and generation 1. Either gives a store fault, whatever the tag, with no entry traffic.
- R3: With write-enable 1, capability-dirty 0 and a set tag, software mode (`req_hw_mode`=0) gives a store fault and issues no read or write.
- R4: In the same case, hardware mode re-reads the entry and writes it back with capability-dirty (bit 61), accessed (bit 6) and dirty (bit 7) set. Write-enable is bit 60 and generation is bit 62. All other bits keep their values. The response then carries `resp_updated`=1 and no store fault.
- R5: With write-enable 1, the access proceeds with no update when capability-dirty is 1 or the tag is 0.
- R6: A store-conditional (`req_cls`=01) is judged on its source tag exactly as a plain store (00) is. Class 11 is handled as a plain store.
- R7: If the re-read entry has write-enable 0, the update is abandoned: no write is issued, and a store fault is reported.
- R8: If the re-read entry already has capability-dirty 1, the access proceeds with no write.
- R9: A refused compare-and-swap (`wr_ok`=0) leads to a fresh read and a new attempt. After MAX_TRIES (default 3) refusals a store fault is reported.
- R10: For an AMO (`req_cls`=10), a store fault suppresses the load-fault candidate. Otherwise a set `req_ld_cand` gives a load fault, also after a successful update. Stores and store-conditionals ignore `req_ld_cand`.
- R11: `req_ready` is high only in IDLE. `resp_valid` is a one-cycle pulse. Read and write requests are never active together.
- R12: After reset the block is in IDLE: `req_ready`=1, and `resp_valid`, `rd_req` and `wr_req` are 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| req_valid | input | 1 | Request present |
| req_ready | output | 1 | Block is idle and accepts a request |
| req_crw | input | 1 | Leaf entry capability write-enable |
| req_cd | input | 1 | Leaf entry capability-dirty |
| req_gen | input | 1 | Leaf entry generation bit |
| req_tag | input | 1 | Tag of the capability to be stored (source tag for store-conditional) |
| req_cls | input | 2 | Access class: 00 store, 01 store-conditional, 10 AMO, 11 as store |
| req_hw_mode | input | 1 | 1 = hardware updates capability-dirty, 0 = trap |
| req_ld_cand | input | 1 | Load-capability fault candidate for an AMO |
| rd_req | output | 1 | Entry re-read request |
| rd_ack | input | 1 | Re-read data valid |
| rd_pte | input | PTE_W | Re-read entry |
| wr_req | output | 1 | Compare-and-swap request |
| wr_expect | output | PTE_W | Value the entry must still hold |
| wr_data | output | PTE_W | New entry value |
| wr_ack | input | 1 | Compare-and-swap finished |
| wr_ok | input | 1 | Compare-and-swap succeeded |
| resp_valid | output | 1 | Result pulse |
| resp_st_flt | output | 1 | Store-capability fault |
| resp_ld_flt | output | 1 | Load-capability fault |
| resp_updated | output | 1 | Entry was written with capability-dirty set |

## Verification
The bench targets the reserved encodings, a tag that is clear, and the store-conditional class. A design that decoded any of these loosely would report the wrong outcome, or would start entry traffic when none should happen. On the hardware path it removes write-enable between translation and re-read, sets capability-dirty early from another agent, and refuses the swap once and then up to the limit. A wrong design would write a reserved entry, write twice, or retry without end. For AMOs it raises the load candidate alongside a store fault and alongside an update, which catches any design that reports both faults at once or drops the load fault after updating.

// File: rtl/cdt_pkg.sv
package cdt_pkg;
    typedef enum logic [1:0] {
        CLS_ST  = 2'b00,
        CLS_SC  = 2'b01,
        CLS_AMO = 2'b10,
        CLS_XST = 2'b11
    } cls_e;

    typedef enum logic [1:0] {
        S_IDLE,
        S_READ,
        S_WRITE,
        S_RESP
    } state_e;

    typedef enum logic [1:0] {
        ACT_PROCEED,
        ACT_FAULT,
        ACT_UPDATE
    } act_e;
endpackage

// File: rtl/cdt_classify.sv
module cdt_classify
    import cdt_pkg::*;
(
    input  logic crw,
    input  logic cd,
    input  logic gen,
    input  logic tag,
    input  logic hw_mode,
    output act_e act
);
    always_comb begin
        if (!crw) begin
            // reserved encodings fault; the legal no-write entry faults on a tag
            act = (cd || gen || tag) ? ACT_FAULT : ACT_PROCEED;
        end else if (cd || !tag) begin
            act = ACT_PROCEED;
        end else begin
            act = hw_mode ? ACT_UPDATE : ACT_FAULT;
        end
    end
endmodule

// File: rtl/cdt_merge.sv
module cdt_merge #(
    parameter int PTE_W  = 64,
    parameter int BIT_A  = 6,
    parameter int BIT_D  = 7,
    parameter int BIT_CD = 61
) (
    input  logic [PTE_W-1:0] cur,
    output logic [PTE_W-1:0] nxt
);
    localparam logic [PTE_W-1:0] SET_MASK =
        (PTE_W'(1) << BIT_A) | (PTE_W'(1) << BIT_D) | (PTE_W'(1) << BIT_CD);

    assign nxt = cur | SET_MASK;
endmodule

// File: rtl/cap_dirty_tracker.sv
module cap_dirty_tracker
    import cdt_pkg::*;
#(
    parameter int PTE_W     = 64,
    parameter int BIT_A     = 6,
    parameter int BIT_D     = 7,
    parameter int BIT_CRW   = 60,
    parameter int BIT_CD    = 61,
    parameter int MAX_TRIES = 3
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             req_valid,
    output logic             req_ready,
    input  logic             req_crw,
    input  logic             req_cd,
    input  logic             req_gen,
    input  logic             req_tag,
    input  logic [1:0]       req_cls,
    input  logic             req_hw_mode,
    input  logic             req_ld_cand,
    output logic             rd_req,
    input  logic             rd_ack,
    input  logic [PTE_W-1:0] rd_pte,
    output logic             wr_req,
    output logic [PTE_W-1:0] wr_expect,
    output logic [PTE_W-1:0] wr_data,
    input  logic             wr_ack,
    input  logic             wr_ok,
    output logic             resp_valid,
    output logic             resp_st_flt,
    output logic             resp_ld_flt,
    output logic             resp_updated
);
    localparam int TRY_W = $clog2(MAX_TRIES + 1);

    state_e             state_q, state_d;
    act_e               act;
    logic [PTE_W-1:0]   entry_q;
    logic [TRY_W-1:0]   tries_q;
    logic               amo_ld_q;
    logic               st_q, ld_q, upd_q;
    logic               last_try;
    logic               is_amo;

    assign is_amo   = (cls_e'(req_cls) == CLS_AMO);
    assign last_try = (int'(tries_q) + 1 >= MAX_TRIES);

    cdt_classify u_classify (
        .crw     (req_crw),
        .cd      (req_cd),
        .gen     (req_gen),
        .tag     (req_tag),
        .hw_mode (req_hw_mode),
        .act     (act)
    );

    cdt_merge #(
        .PTE_W  (PTE_W),
        .BIT_A  (BIT_A),
        .BIT_D  (BIT_D),
        .BIT_CD (BIT_CD)
    ) u_merge (
        .cur (entry_q),
        .nxt (wr_data)
    );

    // state register
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) state_q <= S_IDLE;
        else        state_q <= state_d;
    end

    // next state
    always_comb begin
        state_d = state_q;
        unique case (state_q)
            S_IDLE: begin
                if (req_valid) state_d = (act == ACT_UPDATE) ? S_READ : S_RESP;
            end
            S_READ: begin
                if (rd_ack) begin
                    if (!rd_pte[BIT_CRW] || rd_pte[BIT_CD]) state_d = S_RESP;
                    else                                    state_d = S_WRITE;
                end
            end
            S_WRITE: begin
                if (wr_ack) begin
                    if (wr_ok || last_try) state_d = S_RESP;
                    else                   state_d = S_READ;
                end
            end
            S_RESP:  state_d = S_IDLE;
            default: state_d = S_IDLE;
        endcase
    end

    // per-request data
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            entry_q  <= '0;
            tries_q  <= '0;
            amo_ld_q <= 1'b0;
            st_q     <= 1'b0;
            ld_q     <= 1'b0;
            upd_q    <= 1'b0;
        end else begin
            unique case (state_q)
                S_IDLE: begin
                    if (req_valid) begin
                        amo_ld_q <= is_amo && req_ld_cand;
                        tries_q  <= '0;
                        upd_q    <= 1'b0;
                        st_q     <= (act == ACT_FAULT);
                        ld_q     <= (act == ACT_PROCEED) && is_amo && req_ld_cand;
                    end
                end
                S_READ: begin
                    if (rd_ack) begin
                        entry_q <= rd_pte;
                        if (!rd_pte[BIT_CRW])    st_q <= 1'b1;
                        else if (rd_pte[BIT_CD]) ld_q <= amo_ld_q;
                    end
                end
                S_WRITE: begin
                    if (wr_ack) begin
                        if (wr_ok) begin
                            upd_q <= 1'b1;
                            ld_q  <= amo_ld_q;
                        end else begin
                            tries_q <= tries_q + 1'b1;
                            if (last_try) st_q <= 1'b1;
                        end
                    end
                end
                default: ;
            endcase
        end
    end

    // outputs
    always_comb begin
        req_ready    = (state_q == S_IDLE);
        rd_req       = (state_q == S_READ);
        wr_req       = (state_q == S_WRITE);
        resp_valid   = (state_q == S_RESP);
        wr_expect    = entry_q;
        resp_st_flt  = resp_valid && st_q;
        resp_ld_flt  = resp_valid && ld_q;
        resp_updated = resp_valid && upd_q;
    end
endmodule

// File: rtl/cdt_checker.sv
module cdt_checker #(
    parameter int PTE_W   = 64,
    parameter int BIT_A   = 6,
    parameter int BIT_D   = 7,
    parameter int BIT_CRW = 60,
    parameter int BIT_CD  = 61
) (
    input logic             clk,
    input logic             rst_n,
    input logic             req_valid,
    input logic             req_ready,
    input logic             req_crw,
    input logic             req_cd,
    input logic             req_gen,
    input logic             req_tag,
    input logic             req_hw_mode,
    input logic             rd_req,
    input logic             rd_ack,
    input logic [PTE_W-1:0] rd_pte,
    input logic             wr_req,
    input logic [PTE_W-1:0] wr_expect,
    input logic [PTE_W-1:0] wr_data,
    input logic             resp_valid,
    input logic             resp_st_flt,
    input logic             resp_ld_flt,
    input logic             resp_updated
);
    localparam logic [PTE_W-1:0] KEEP =
        ~((PTE_W'(1) << BIT_A) | (PTE_W'(1) << BIT_D) | (PTE_W'(1) << BIT_CD));

    logic accept;
    assign accept = req_valid && req_ready;

    // R2
    reserved_faults_chk: assert property (@(posedge clk) disable iff (!rst_n)
        accept && !req_crw && (req_cd || req_gen) |=> resp_valid && resp_st_flt && !resp_updated);

    // R3
    sw_mode_traps_chk: assert property (@(posedge clk) disable iff (!rst_n)
        accept && req_crw && !req_cd && req_tag && !req_hw_mode |=> resp_valid && resp_st_flt);

    // R4
    wb_sets_bits_chk: assert property (@(posedge clk) disable iff (!rst_n)
        wr_req |-> wr_data[BIT_CD] && wr_data[BIT_A] && wr_data[BIT_D] && wr_data[BIT_CRW]
                   && ((wr_data & KEEP) == (wr_expect & KEEP)));

    // R5
    dirty_page_proceeds_chk: assert property (@(posedge clk) disable iff (!rst_n)
        accept && req_crw && req_cd |=> resp_valid && !resp_st_flt && !resp_updated);

    // R7
    lost_write_enable_chk: assert property (@(posedge clk) disable iff (!rst_n)
        rd_req && rd_ack && !rd_pte[BIT_CRW] |=> resp_valid && resp_st_flt && !resp_updated);

    // R10
    one_fault_only_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !(resp_st_flt && resp_ld_flt));

    // R11
    resp_pulse_chk: assert property (@(posedge clk) disable iff (!rst_n)
        resp_valid |=> !resp_valid);

    // R11
    one_bus_op_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $onehot0({rd_req, wr_req, resp_valid, req_ready}));
endmodule

bind cap_dirty_tracker cdt_checker #(
    .PTE_W   (PTE_W),
    .BIT_A   (BIT_A),
    .BIT_D   (BIT_D),
    .BIT_CRW (BIT_CRW),
    .BIT_CD  (BIT_CD)
) chk_i (
    .clk          (clk),
    .rst_n        (rst_n),
    .req_valid    (req_valid),
    .req_ready    (req_ready),
    .req_crw      (req_crw),
    .req_cd       (req_cd),
    .req_gen      (req_gen),
    .req_tag      (req_tag),
    .req_hw_mode  (req_hw_mode),
    .rd_req       (rd_req),
    .rd_ack       (rd_ack),
    .rd_pte       (rd_pte),
    .wr_req       (wr_req),
    .wr_expect    (wr_expect),
    .wr_data      (wr_data),
    .resp_valid   (resp_valid),
    .resp_st_flt  (resp_st_flt),
    .resp_ld_flt  (resp_ld_flt),
    .resp_updated (resp_updated)
);

// File: tb/cap_dirty_tracker_tb_top.sv
module cap_dirty_tracker_tb_top;
    localparam int PTE_W = 64;

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    always #2.5 clk = ~clk;

    logic             req_valid = 1'b0, req_ready;
    logic             req_crw = 1'b0, req_cd = 1'b0, req_gen = 1'b0, req_tag = 1'b0;
    logic [1:0]       req_cls = 2'b00;
    logic             req_hw_mode = 1'b0, req_ld_cand = 1'b0;
    logic             rd_req, rd_ack = 1'b0;
    logic [PTE_W-1:0] rd_pte = '0;
    logic             wr_req, wr_ack = 1'b0, wr_ok = 1'b0;
    logic [PTE_W-1:0] wr_expect, wr_data;
    logic             resp_valid, resp_st_flt, resp_ld_flt, resp_updated;

    cap_dirty_tracker dut_i (.*);

    typedef struct packed {
        logic crw, cd, gen, tag;
        logic [1:0] cls;
        logic hw, ldc, mcrw, mcd;
        logic [1:0] fails;
        logic est, eld, eupd;
    } vec_t;

    localparam int NV = 20;
    localparam vec_t VECS [NV] = '{
        '{1'b0,1'b0,1'b0,1'b1,2'd0,1'b0,1'b0,1'b1,1'b0,2'd0,1'b1,1'b0,1'b0},
        '{1'b0,1'b0,1'b0,1'b0,2'd0,1'b1,1'b0,1'b1,1'b0,2'd0,1'b0,1'b0,1'b0},
        '{1'b0,1'b1,1'b0,1'b0,2'd0,1'b1,1'b0,1'b1,1'b0,2'd0,1'b1,1'b0,1'b0},
        '{1'b0,1'b0,1'b1,1'b1,2'd0,1'b1,1'b0,1'b1,1'b0,2'd0,1'b1,1'b0,1'b0},
        '{1'b1,1'b0,1'b0,1'b1,2'd0,1'b0,1'b0,1'b1,1'b0,2'd0,1'b1,1'b0,1'b0},
        '{1'b1,1'b0,1'b0,1'b1,2'd0,1'b1,1'b0,1'b1,1'b0,2'd0,1'b0,1'b0,1'b1},
        '{1'b1,1'b1,1'b0,1'b1,2'd0,1'b1,1'b0,1'b1,1'b0,2'd0,1'b0,1'b0,1'b0},
        '{1'b1,1'b0,1'b1,1'b0,2'd2,1'b1,1'b0,1'b1,1'b0,2'd0,1'b0,1'b0,1'b0},
        '{1'b1,1'b0,1'b0,1'b1,2'd1,1'b1,1'b0,1'b1,1'b0,2'd0,1'b0,1'b0,1'b1},
        '{1'b1,1'b0,1'b0,1'b1,2'd1,1'b0,1'b0,1'b1,1'b0,2'd0,1'b1,1'b0,1'b0},
        '{1'b0,1'b0,1'b0,1'b1,2'd1,1'b0,1'b0,1'b1,1'b0,2'd0,1'b1,1'b0,1'b0},
        '{1'b0,1'b0,1'b0,1'b1,2'd2,1'b0,1'b1,1'b1,1'b0,2'd0,1'b1,1'b0,1'b0},
        '{1'b1,1'b1,1'b0,1'b0,2'd2,1'b0,1'b1,1'b1,1'b0,2'd0,1'b0,1'b1,1'b0},
        '{1'b1,1'b1,1'b0,1'b1,2'd0,1'b0,1'b1,1'b1,1'b0,2'd0,1'b0,1'b0,1'b0},
        '{1'b1,1'b0,1'b0,1'b1,2'd2,1'b1,1'b1,1'b1,1'b0,2'd0,1'b0,1'b1,1'b1},
        '{1'b1,1'b0,1'b0,1'b1,2'd0,1'b1,1'b0,1'b0,1'b0,2'd0,1'b1,1'b0,1'b0},
        '{1'b1,1'b0,1'b0,1'b1,2'd0,1'b1,1'b0,1'b1,1'b1,2'd0,1'b0,1'b0,1'b0},
        '{1'b1,1'b0,1'b0,1'b1,2'd0,1'b1,1'b0,1'b1,1'b0,2'd1,1'b0,1'b0,1'b1},
        '{1'b1,1'b0,1'b0,1'b1,2'd0,1'b1,1'b0,1'b1,1'b0,2'd3,1'b1,1'b0,1'b0},
        '{1'b1,1'b0,1'b0,1'b1,2'd3,1'b0,1'b1,1'b1,1'b0,2'd0,1'b1,1'b0,1'b0}
    };

    function automatic string vtag(int i);
        case (i)
            0, 1:       return "R1";
            2, 3:       return "R2";
            4:          return "R3";
            5:          return "R4";
            6, 7:       return "R5";
            8, 9, 10:   return "R6";
            11, 12, 13: return "R10";
            14:         return "R10";
            15:         return "R7";
            16:         return "R8";
            17, 18:     return "R9";
            default:    return "R6";
        endcase
    endfunction

    localparam logic [PTE_W-1:0] BASE     = 64'h4000_00ab_cdef_0301; // gen bit 62 set, A/D clear
    localparam logic [PTE_W-1:0] UPD_BITS = (64'd1 << 61) | (64'd1 << 6) | (64'd1 << 7);

    int n_chk = 0;
    int n_bad = 0;
    logic [PTE_W-1:0] mem;
    int fails_left;

    task automatic chk(string tag, string what, logic [PTE_W-1:0] act, logic [PTE_W-1:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_bad++;
            $display("FAIL %s %s: got %0h expected %0h", tag, what, act, exp);
        end
    endtask

    task automatic run_vec(int i);
        vec_t v = VECS[i];
        logic [PTE_W-1:0] init;
        logic got_st, got_ld, got_upd, seen;
        init = BASE | ({63'd0, v.mcrw} << 60) | ({63'd0, v.mcd} << 61);
        @(negedge clk);
        mem = init;
        fails_left = int'(v.fails);
        req_crw = v.crw; req_cd = v.cd; req_gen = v.gen; req_tag = v.tag;
        req_cls = v.cls; req_hw_mode = v.hw; req_ld_cand = v.ldc;
        req_valid = 1'b1;
        @(negedge clk);
        req_valid = 1'b0;
        chk("R11", "ready while busy", {63'd0, req_ready}, 64'd0);
        seen = 1'b0; got_st = 1'b0; got_ld = 1'b0; got_upd = 1'b0;
        for (int k = 0; k < 40 && !seen; k++) begin
            if (resp_valid) begin
                seen = 1'b1;
                got_st = resp_st_flt; got_ld = resp_ld_flt; got_upd = resp_updated;
            end else begin
                rd_ack = rd_req;
                rd_pte = mem;
                if (wr_req) begin
                    wr_ack = 1'b1;
                    if (fails_left > 0) begin
                        wr_ok = 1'b0;
                        fails_left--;
                    end else if (wr_expect == mem) begin
                        wr_ok = 1'b1;
                        mem = wr_data;
                    end else begin
                        wr_ok = 1'b0;
                    end
                end else begin
                    wr_ack = 1'b0;
                    wr_ok = 1'b0;
                end
                @(negedge clk);
            end
        end
        rd_ack = 1'b0; wr_ack = 1'b0; wr_ok = 1'b0;
        chk(vtag(i), $sformatf("vec %0d response seen", i), {63'd0, seen}, 64'd1);
        chk(vtag(i), $sformatf("vec %0d result {st,ld,upd}", i),
            {61'd0, got_st, got_ld, got_upd}, {61'd0, v.est, v.eld, v.eupd});
        chk(vtag(i), $sformatf("vec %0d entry after", i), mem, v.eupd ? (init | UPD_BITS) : init);
        @(negedge clk);
        chk("R11", "resp pulse one cycle", {63'd0, resp_valid}, 64'd0);
    endtask

    initial begin
        repeat (20000) @(posedge clk);
        n_bad++;
        $display("FAIL watchdog: got timeout expected completion");
        $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
        $finish;
    end

    initial begin
        repeat (3) @(negedge clk);
        // R12 reset state
        chk("R12", "reset ready", {63'd0, req_ready}, 64'd1);
        chk("R12", "reset idle outputs", {61'd0, resp_valid, rd_req, wr_req}, 64'd0);
        rst_n = 1'b1;
        @(negedge clk);
        chk("R12", "idle after release", {63'd0, req_ready}, 64'd1);

        for (int i = 0; i < NV; i++) run_vec(i);

        // R3: software mode must not touch the entry bus
        @(negedge clk);
        req_crw = 1'b1; req_cd = 1'b0; req_gen = 1'b0; req_tag = 1'b1;
        req_cls = 2'b00; req_hw_mode = 1'b0; req_ld_cand = 1'b0; req_valid = 1'b1;
        @(negedge clk);
        req_valid = 1'b0;
        chk("R3", "no read in software mode", {62'd0, rd_req, wr_req}, 64'd0);
        chk("R3", "fault response", {62'd0, resp_valid, resp_st_flt}, 64'd3);

        // R2: reserved entry with hardware mode issues no read
        @(negedge clk);
        req_crw = 1'b0; req_cd = 1'b1; req_tag = 1'b1; req_hw_mode = 1'b1; req_valid = 1'b1;
        @(negedge clk);
        req_valid = 1'b0;
        chk("R2", "no read on reserved entry", {62'd0, rd_req, wr_req}, 64'd0);
        chk("R2", "reserved fault", {62'd0, resp_valid, resp_st_flt}, 64'd3);

        repeat (2) @(negedge clk);
        $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
        $finish;
    end
endmodule